// File: doc/BRIEF.md
# Register File with Load-Delay Hold

This block is the general-purpose register store of a single-issue core whose load results are architecturally late by one instruction. It holds a parameterised number of entries (32 by default) of a parameterised width (32 bits by default). Two combinational read ports serve operand fetch. One write port takes results that are visible at once. A second write port takes load results, which enter the array immediately but stay hidden from the next instruction.

When a load result is written, the block records the register's previous contents. An `adv` strobe marks the clock edge that ends an instruction. For the whole instruction that follows the load, any ordinary read of that register returns the recorded previous value. Each read port has a `raw` qualifier that skips this hold and returns the newest array contents, as partial-word merge loads need. A `flush` discards every hold record. An immediate write to the register that is currently held also ends the hold.

Top module: `regfile_ldslot`

## Requirements
- R1: Entry 0 always reads zero on both ports. Immediate and delayed writes to entry 0 are discarded, and a delayed write to entry 0 creates no hold.
- R2: An immediate write (`wr_en`) to entry n≠0 is visible on both ports in the cycle after the clock edge.
- R3: A delayed write (`ld_en`) at an edge without `adv` is visible to ordinary reads from the next cycle until the end of the instruction that issued it.
- R4: During the instruction after the one that issued a delayed write, an ordinary read (`raw`=0) of that entry returns the value the entry held before the delayed write.
- R5: At every `adv` edge, the pending record becomes the active record and the pending slot is cleared. From the second `adv` after a delayed write, ordinary reads return the loaded value.
- R6: A read with `raw`=1 returns the newest array contents, including a delayed value still under hold.
- R7: `flush` clears both the pending and the active hold. From the next cycle, reads return the array contents. `flush` takes priority over `adv`.
- R8: An immediate write to the entry under active hold (without `adv`) cancels the hold. Reads then return the written value.
- R9: At most one delayed write is issued per instruction. `ld_en` is never high while a pending record exists.
- R10: After reset, every entry reads zero and no hold is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| adv | input | 1 | This edge ends the current instruction |
| flush | input | 1 | Cancel all hold records |
| wr_en | input | 1 | Immediate write enable |
| wr_idx | input | 5 | Immediate write entry |
| wr_data | input | 32 | Immediate write value |
| ld_en | input | 1 | Delayed write enable |
| ld_idx | input | 5 | Delayed write entry |
| ld_data | input | 32 | Delayed write value |
| rd_a_idx | input | 5 | Port A entry |
| rd_a_raw | input | 1 | Port A skips the hold |
| rd_a_data | output | 32 | Port A value |
| rd_b_idx | input | 5 | Port B entry |
| rd_b_raw | input | 1 | Port B skips the hold |
| rd_b_data | output | 32 | Port B value |

## Verification
Reads are combinational, so a read reflects every write and record change made at the previous clock edge. The bench drives inputs just after the falling edge and compares both ports one time unit later, before the next rising edge. Delayed values need care in counting: after `ld_en` they are visible at once, hidden for one whole instruction after the next `adv`, and visible again after the second `adv`. The directed checks count those strobes explicitly. A random phase compares both ports on every cycle against a behavioural model that is updated at each rising edge.

// File: rtl/regfile_ldslot.sv
module regfile_ldslot #(
  parameter int NREG = 32,
  parameter int XLEN = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     adv,
  input  logic                     flush,
  input  logic                     wr_en,
  input  logic [$clog2(NREG)-1:0]  wr_idx,
  input  logic [XLEN-1:0]          wr_data,
  input  logic                     ld_en,
  input  logic [$clog2(NREG)-1:0]  ld_idx,
  input  logic [XLEN-1:0]          ld_data,
  input  logic [$clog2(NREG)-1:0]  rd_a_idx,
  input  logic                     rd_a_raw,
  output logic [XLEN-1:0]          rd_a_data,
  input  logic [$clog2(NREG)-1:0]  rd_b_idx,
  input  logic                     rd_b_raw,
  output logic [XLEN-1:0]          rd_b_data
);
  localparam int AW = $clog2(NREG);

  logic [XLEN-1:0] mem [NREG];
  logic            pnd_v, act_v, nx_v;
  logic [AW-1:0]   pnd_i, act_i, nx_i;
  logic [XLEN-1:0] pnd_o, act_o, nx_o;

  wire wr_ok = wr_en && (wr_idx != '0);
  wire ld_ok = ld_en && (ld_idx != '0);

  assign nx_v = ld_ok ? 1'b1        : pnd_v;
  assign nx_i = ld_ok ? ld_idx      : pnd_i;
  assign nx_o = ld_ok ? mem[ld_idx] : pnd_o;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
    end else begin
      if (wr_ok) mem[wr_idx] <= wr_data;
      if (ld_ok) mem[ld_idx] <= ld_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      pnd_v <= 1'b0;
      act_v <= 1'b0;
      pnd_i <= '0;
      act_i <= '0;
      pnd_o <= '0;
      act_o <= '0;
    end else if (adv) begin
      act_v <= nx_v;
      act_i <= nx_i;
      act_o <= nx_o;
      pnd_v <= 1'b0;
    end else begin
      pnd_v <= nx_v;
      pnd_i <= nx_i;
      pnd_o <= nx_o;
      if (wr_ok && act_v && act_i == wr_idx) act_v <= 1'b0;
    end
  end

  function automatic logic [XLEN-1:0] rd(input logic [AW-1:0] idx, input logic raw);
    if (idx == '0)                         return '0;
    else if (!raw && act_v && act_i == idx) return act_o;
    else                                   return mem[idx];
  endfunction

  assign rd_a_data = rd(rd_a_idx, rd_a_raw);
  assign rd_b_data = rd(rd_b_idx, rd_b_raw);
endmodule

// File: rtl/regfile_ldslot_chk.sv
module regfile_ldslot_chk #(
  parameter int AW   = 5,
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            adv,
  input logic            flush,
  input logic            ld_en,
  input logic [AW-1:0]   ld_idx,
  input logic [XLEN-1:0] ld_data,
  input logic [AW-1:0]   rd_a_idx,
  input logic            rd_a_raw,
  input logic [XLEN-1:0] rd_a_data,
  input logic            pnd_v,
  input logic            act_v
);
  assert_zero_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_a_idx == '0 |-> rd_a_data == '0);

  assert_raw_sees_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && ld_idx != '0) |=> ((rd_a_raw && rd_a_idx == $past(ld_idx)) |-> rd_a_data == $past(ld_data)));

  assert_adv_clears_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> !pnd_v);

  assert_flush_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!pnd_v && !act_v));

  assert_one_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pnd_v |-> !ld_en);

  assert_zero_load_no_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && ld_idx == '0 && !pnd_v && !adv) |=> !pnd_v);
endmodule

bind regfile_ldslot regfile_ldslot_chk #(.AW(AW), .XLEN(XLEN)) u_chk (.*);

// File: tb/regfile_ldslot_tb.sv
module regfile_ldslot_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0, adv = 0, flush = 0;
  logic        wr_en = 0, ld_en = 0, rd_a_raw = 0, rd_b_raw = 0;
  logic [4:0]  wr_idx = 0, ld_idx = 0, rd_a_idx = 0, rd_b_idx = 0;
  logic [31:0] wr_data = 0, ld_data = 0;
  logic [31:0] rd_a_data, rd_b_data;

  int checks = 0, fails = 0;

  regfile_ldslot u_dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [31:0] mm [32];
  bit mpv, mav;
  int mpi, mai;
  logic [31:0] mpo, mao;

  function automatic logic [31:0] mread(int idx, bit raw);
    if (idx == 0) return 0;
    if (!raw && mav && mai == idx) return mao;
    return mm[idx];
  endfunction

  task automatic model_edge();
    bit nv; int ni; logic [31:0] no;
    nv = mpv; ni = mpi; no = mpo;
    if (ld_en && ld_idx != 0) begin nv = 1; ni = ld_idx; no = mm[ld_idx]; end
    if (wr_en && wr_idx != 0) mm[wr_idx] = wr_data;
    if (ld_en && ld_idx != 0) mm[ld_idx] = ld_data;
    if (flush) begin mpv = 0; mav = 0; end
    else if (adv) begin mav = nv; mai = ni; mao = no; mpv = 0; end
    else begin
      mpv = nv; mpi = ni; mpo = no;
      if (wr_en && wr_idx != 0 && mav && mai == wr_idx) mav = 0;
    end
  endtask

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic quiet();
    adv = 0; flush = 0; wr_en = 0; ld_en = 0; rd_a_raw = 0; rd_b_raw = 0;
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    quiet();
  endtask

  task automatic rdab(int ia, bit ra, int ib, bit rb);
    rd_a_idx = ia; rd_a_raw = ra; rd_b_idx = ib; rd_b_raw = rb; #1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) mm[i] = 0;
    mpv = 0; mav = 0; mpi = 0; mai = 0; mpo = 0; mao = 0;
    @(negedge clk); @(negedge clk);
    rst_n = 1;

    rdab(3, 0, 31, 0); chk("R10 reset entry 3", rd_a_data, 0); chk("R10 reset entry 31", rd_b_data, 0);

    wr_en = 1; wr_idx = 5; wr_data = 32'hAAAA_0005; tick();
    rdab(5, 0, 5, 1); chk("R2 port A", rd_a_data, 32'hAAAA_0005); chk("R2 port B", rd_b_data, 32'hAAAA_0005);

    ld_en = 1; ld_idx = 5; ld_data = 32'hBBBB_0005; adv = 1; tick();
    rdab(5, 0, 5, 1); chk("R4 old value held", rd_a_data, 32'hAAAA_0005); chk("R6 raw sees new", rd_b_data, 32'hBBBB_0005);
    adv = 1; tick();
    rdab(5, 0, 5, 0); chk("R5 new after second adv", rd_a_data, 32'hBBBB_0005);

    ld_en = 1; ld_idx = 6; ld_data = 32'h1234_5678; tick();
    rdab(6, 0, 0, 0); chk("R3 visible in issuing instruction", rd_a_data, 32'h1234_5678);
    adv = 1; tick();
    rdab(6, 0, 6, 1); chk("R4 hold after adv", rd_a_data, 0); chk("R6 raw during hold", rd_b_data, 32'h1234_5678);
    adv = 1; tick();
    rdab(6, 0, 0, 0); chk("R5 released", rd_a_data, 32'h1234_5678);

    ld_en = 1; ld_idx = 7; ld_data = 32'h7777_7777; adv = 1; tick();
    rdab(7, 0, 0, 0); chk("R4 before flush", rd_a_data, 0);
    flush = 1; tick();
    rdab(7, 0, 0, 0); chk("R7 flush cancels active", rd_a_data, 32'h7777_7777);

    ld_en = 1; ld_idx = 8; ld_data = 32'h8888_8888; tick();
    flush = 1; adv = 1; tick();
    rdab(8, 0, 0, 0); chk("R7 flush cancels pending", rd_a_data, 32'h8888_8888);

    ld_en = 1; ld_idx = 9; ld_data = 32'h9999_9999; adv = 1; tick();
    wr_en = 1; wr_idx = 9; wr_data = 32'hC0DE_0009; tick();
    rdab(9, 0, 0, 0); chk("R8 write cancels hold", rd_a_data, 32'hC0DE_0009);
    adv = 1; tick();
    rdab(9, 0, 0, 0); chk("R8 stays after adv", rd_a_data, 32'hC0DE_0009);

    wr_en = 1; wr_idx = 0; wr_data = 32'hFFFF_FFFF; tick();
    rdab(0, 0, 0, 1); chk("R1 imm write to 0", rd_a_data, 0); chk("R1 raw read of 0", rd_b_data, 0);
    ld_en = 1; ld_idx = 0; ld_data = 32'hFFFF_FFFF; adv = 1; tick();
    rdab(0, 0, 5, 0); chk("R1 load to 0", rd_a_data, 0); chk("R1 no hold from load to 0", rd_b_data, 32'hBBBB_0005);

    for (int c = 0; c < 4000; c++) begin
      adv = ($urandom % 3) == 0;
      flush = ($urandom % 20) == 0;
      wr_en = ($urandom % 2) == 0;
      wr_idx = $urandom % 8; wr_data = $urandom;
      ld_en = !mpv && (($urandom % 2) == 0);
      ld_idx = $urandom % 8; ld_data = $urandom;
      rdab($urandom % 8, ($urandom % 4) == 0, $urandom % 8, ($urandom % 4) == 0);
      chk("R2 random port A", rd_a_data, mread(rd_a_idx, rd_a_raw));
      chk("R4 random port B", rd_b_data, mread(rd_b_idx, rd_b_raw));
      tick();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule